// File: doc/BRIEF.md
# Multiplexed Host Port Ready Controller

This block is the slave side of a 16-bit multiplexed host port. Through it an external host reaches three 32-bit registers: a control register, an address register and a data register. Every 32-bit transfer goes over the bus as two halfwords, and a halfword-select pin says which half the current access carries. An access is taken when the internal strobe becomes active. The internal strobe is the external strobe gated by chip select, and it passes through a short synchronizer.

A wait output tells the host to stall. It is raised on three kinds of access only: a halfword written to the address register, the first halfword of a data read, and the first auto-increment read after the prefetch has been lost. Data reads and address writes go to internal memory through a single-outstanding request/acknowledge port. In auto-increment mode the next word is prefetched, so a run of reads completes without stalls. Data writes are posted and never stall the host.

Top module: `hostport_rdy_ctrl`

## Requirements
- R1: After reset, wait_o and mem_req_o are low.
- R2: reg_sel_i selects the register: 2'b00 is the control register, 2'b10 is the address register, 2'b11 is the data register at a fixed address, and 2'b01 is the data register with auto-increment. Control register halfwords written with half_i=0 (bits 15:0) and half_i=1 (bits 31:16) read back unchanged.
- R3: wait_o is low whenever cs_ni is high, including while an access that was started is still waiting on memory.
- R4: Reads of the control or address register, and writes of the control register, never raise wait_o.
- R5: Each halfword written to the address register raises wait_o SYNC_STAGES+1 clock edges after the strobe becomes active. This holds for both halves. The block then issues a memory fetch, and wait_o falls on the first clock edge after mem_ack_i is sampled high.
- R6: In a fixed-address data read, the first halfword raises wait_o, fetches the word at the address register and returns bits 15:0. The second halfword does not wait and returns bits 31:16 of the latched word.
- R7: In auto-increment data reads, only the first halfword of the first read after the prefetch was lost raises wait_o. Later reads return consecutive words at the address plus 4, 8 and so on, with no wait.
- R8: Each completed auto-increment data access (read second halfword, or write second halfword) advances the address register by 4.
- R9: Writing the address register or the data register discards any prefetched or in-flight prefetched word. The next auto-increment read waits and returns the word at the current address.
- R10: A data write latches the first halfword and posts a memory write of {second, first} to the address register value on the second halfword. It never raises wait_o.
- R11: Once mem_req_o is raised, it stays high with a stable address and write flag until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| strb_ni | input | 1 | Access strobe, active low |
| reg_sel_i | input | 2 | Register select code |
| rnw_i | input | 1 | 1 = read, 0 = write |
| half_i | input | 1 | 0 = first halfword (bits 15:0), 1 = second (bits 31:16) |
| bus_wdata_i | input | HALF_W | Write halfword from the host |
| bus_rdata_o | output | HALF_W | Read halfword to the host |
| wait_o | output | 1 | Stall request to the host, active high |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 2*HALF_W | Memory byte address |
| mem_wdata_o | output | 2*HALF_W | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one-cycle pulse |
| mem_rdata_i | input | 2*HALF_W | Memory read data, valid with mem_ack_i |

## Verification
The bench applies the strobe just after a falling edge. It then counts SYNC_STAGES+1 rising edges and samples wait_o at the next falling edge, because that is when the synchronizer, edge detector and wait register have all updated. When a wait is expected, the bench records the cycle in which its memory model drives the acknowledge. It then requires wait_o to be seen low exactly one rising edge later, and it samples read data only after that point. Posted writes are compared when the memory model accepts them, several cycles after the second halfword, so they are matched through a queue rather than at a fixed cycle.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_AINC = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_DATA = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_HOST  = 2'd1,
    OP_PREF  = 2'd2,
    OP_WRITE = 2'd3
  } mem_op_e;
endpackage

// File: rtl/hp_strobe_edge.sv
module hp_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= stb_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[SYNC_STAGES-2:0], stb_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[SYNC_STAGES-1];

  assign edge_o = chain_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/hp_mem_port.sv
module hp_mem_port
  import hostport_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [WORD_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              host_req_i,
  input  logic              pf_req_i,
  input  logic [WORD_W-1:0] cur_addr_i,
  output mem_op_e           grant_o,
  output mem_op_e           done_o,
  output mem_op_e           out_op_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i
);
  logic              req_q;
  mem_op_e           op_q;
  logic [WORD_W-1:0] addr_q, wdata_q;

  // posted write first keeps write-then-read ordering
  always_comb begin
    grant_o = OP_NONE;
    if (!req_q) begin
      if (wr_req_i)        grant_o = OP_WRITE;
      else if (host_req_i) grant_o = OP_HOST;
      else if (pf_req_i)   grant_o = OP_PREF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      req_q   <= 1'b0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_q && mem_ack_i) begin
      req_q <= 1'b0;
    end else if (grant_o != OP_NONE) begin
      req_q   <= 1'b1;
      op_q    <= grant_o;
      addr_q  <= (grant_o == OP_WRITE) ? wr_addr_i : cur_addr_i;
      wdata_q <= wr_data_i;
    end

  assign done_o      = (req_q && mem_ack_i) ? op_q : OP_NONE;
  assign out_op_o    = req_q ? op_q : OP_NONE;
  assign mem_req_o   = req_q;
  assign mem_we_o    = req_q && (op_q == OP_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/hp_rd_mux.sv
module hp_rd_mux
  import hostport_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [1:0]        sel_i,
  input  logic              half_i,
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [HALF_W-1:0] data_o
);
  logic [WORD_W-1:0] src;

  always_comb begin
    case (reg_sel_e'(sel_i))
      SEL_CTRL: src = ctrl_i;
      SEL_ADDR: src = addr_i;
      default:  src = word_i;
    endcase
  end

  assign data_o = half_i ? src[WORD_W-1:HALF_W] : src[HALF_W-1:0];
endmodule

// File: rtl/hostport_rdy_ctrl.sv
module hostport_rdy_ctrl
  import hostport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_W      = 16,
  parameter int ADDR_STEP   = 4,
  localparam int WORD_W     = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              strb_ni,
  input  logic [1:0]        reg_sel_i,
  input  logic              rnw_i,
  input  logic              half_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              wait_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

  logic     stb_edge;
  reg_sel_e sel;
  mem_op_e  grant, done, out_op;

  logic [WORD_W-1:0] ctrl_q, addr_q, word_q, pf_buf_q, wr_addr_q, wr_data_q;
  logic [HALF_W-1:0] wr_lo_q;
  logic wait_q, wait_pf_q, host_pend_q, wr_pend_q;
  logic pf_valid_q, pf_pend_q, pf_drop_q;
  logic pf_kill, pf_inflight, pf_arrive;

  assign sel = reg_sel_e'(reg_sel_i);

  hp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (~cs_ni & ~strb_ni),
    .edge_o (stb_edge)
  );

  hp_mem_port #(.WORD_W(WORD_W)) i_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_pend_q),
    .wr_addr_i   (wr_addr_q),
    .wr_data_i   (wr_data_q),
    .host_req_i  (host_pend_q),
    .pf_req_i    (pf_pend_q),
    .cur_addr_i  (addr_q),
    .grant_o     (grant),
    .done_o      (done),
    .out_op_o    (out_op),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i)
  );

  hp_rd_mux #(.HALF_W(HALF_W)) i_mux (
    .sel_i  (reg_sel_i),
    .half_i (half_i),
    .ctrl_i (ctrl_q),
    .addr_i (addr_q),
    .word_i (word_q),
    .data_o (bus_rdata_o)
  );

  // a prefetch issued this cycle or still outstanding must be dropped
  assign pf_kill     = ((out_op == OP_PREF) && (done != OP_PREF)) || (grant == OP_PREF);
  assign pf_inflight = pf_pend_q || ((out_op == OP_PREF) && !pf_drop_q);
  assign pf_arrive   = (done == OP_PREF) && !pf_drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      addr_q      <= '0;
      word_q      <= '0;
      pf_buf_q    <= '0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      wr_lo_q     <= '0;
      wait_q      <= 1'b0;
      wait_pf_q   <= 1'b0;
      host_pend_q <= 1'b0;
      wr_pend_q   <= 1'b0;
      pf_valid_q  <= 1'b0;
      pf_pend_q   <= 1'b0;
      pf_drop_q   <= 1'b0;
    end else begin
      case (grant)
        OP_WRITE: wr_pend_q   <= 1'b0;
        OP_HOST:  host_pend_q <= 1'b0;
        OP_PREF:  pf_pend_q   <= 1'b0;
        default:  ;
      endcase

      if (done == OP_HOST) begin
        word_q <= mem_rdata_i;
        wait_q <= 1'b0;
      end
      if (done == OP_PREF) begin
        pf_drop_q <= 1'b0;
        if (!pf_drop_q) begin
          if (wait_pf_q) begin
            word_q    <= mem_rdata_i;
            wait_q    <= 1'b0;
            wait_pf_q <= 1'b0;
          end else begin
            pf_buf_q   <= mem_rdata_i;
            pf_valid_q <= 1'b1;
          end
        end
      end

      if (stb_edge) begin
        case (sel)
          SEL_CTRL: begin
            if (!rnw_i) begin
              if (half_i) ctrl_q[WORD_W-1:HALF_W] <= bus_wdata_i;
              else        ctrl_q[HALF_W-1:0]      <= bus_wdata_i;
            end
          end
          SEL_ADDR: begin
            if (!rnw_i) begin
              if (half_i) addr_q[WORD_W-1:HALF_W] <= bus_wdata_i;
              else        addr_q[HALF_W-1:0]      <= bus_wdata_i;
              host_pend_q <= 1'b1;
              wait_q      <= 1'b1;
              pf_valid_q  <= 1'b0;
              pf_pend_q   <= 1'b0;
              if (pf_kill) pf_drop_q <= 1'b1;
            end
          end
          default: begin // data register, fixed or auto-increment
            if (rnw_i) begin
              if (!half_i) begin
                if (sel == SEL_DATA) begin
                  host_pend_q <= 1'b1;
                  wait_q      <= 1'b1;
                end else if (pf_valid_q) begin
                  word_q     <= pf_buf_q;
                  pf_valid_q <= 1'b0;
                end else if (pf_arrive) begin
                  word_q     <= mem_rdata_i;
                  pf_valid_q <= 1'b0;
                end else if (pf_inflight) begin
                  wait_q    <= 1'b1;
                  wait_pf_q <= 1'b1;
                end else begin
                  host_pend_q <= 1'b1;
                  wait_q      <= 1'b1;
                end
              end else if (sel == SEL_AINC) begin
                addr_q    <= addr_q + STEP;
                pf_pend_q <= 1'b1;
              end
            end else begin
              if (!half_i) begin
                wr_lo_q <= bus_wdata_i;
              end else begin
                wr_pend_q  <= 1'b1;
                wr_addr_q  <= addr_q;
                wr_data_q  <= {bus_wdata_i, wr_lo_q};
                pf_valid_q <= 1'b0;
                pf_pend_q  <= 1'b0;
                if (pf_kill) pf_drop_q <= 1'b1;
                if (sel == SEL_AINC) addr_q <= addr_q + STEP;
              end
            end
          end
        endcase
      end
    end
  end

  assign wait_o = wait_q & ~cs_ni;

  // R5
  wait_from_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_q) |-> $past(stb_edge));

  // R5
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && done == OP_HOST) |=> !wait_q);

  // R4
  reg_read_nowait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_edge && rnw_i && !wait_q && (sel == SEL_CTRL || sel == SEL_ADDR)) |=> !wait_q);

  // R7
  pf_hit_nowait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_edge && rnw_i && !half_i && sel == SEL_AINC && pf_valid_q && !wait_q) |=> !wait_q);
endmodule

// File: tb/test_hostport_rdy_ctrl.sv
module test_hostport_rdy_ctrl;
  localparam int SYNC    = 2;
  localparam int MEM_LAT = 3;
  localparam int IDLE    = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, strb_ni = 1'b1, rnw_i = 1'b1, half_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'b00;
  logic [15:0] bus_wdata_i = '0, bus_rdata_o;
  logic        wait_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  int n_chk = 0, n_fail = 0, cyc = 0, ack_cyc = 0;
  logic [31:0] mem_store [logic [31:0]];
  logic [15:0] exp_val [$];
  string       exp_tag [$];
  logic [31:0] exp_wa [$], exp_wd [$];
  event        rd_ev;
  logic [31:0] ea;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  hostport_rdy_ctrl #(.SYNC_STAGES(SYNC)) i_hostport_rdy_ctrl (
    .clk_i, .rst_ni, .cs_ni, .strb_ni, .reg_sel_i, .rnw_i, .half_i,
    .bus_wdata_i, .bus_rdata_o, .wait_o, .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    if (mem_store.exists(a)) return mem_store[a];
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h1111};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model and write monitor
  initial begin : mem_model
    int age = 0;
    logic [31:0] a0 = '0, d0 = '0;
    logic w0 = 1'b0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (age == 0) begin
          a0 = mem_addr_o; w0 = mem_we_o; d0 = mem_wdata_o;
        end else begin
          check(mem_addr_o == a0 && mem_we_o == w0, "R11", mem_addr_o, a0);
        end
        age++;
        if (age == MEM_LAT) begin
          if (w0) begin
            mem_store[a0] = d0;
            if (exp_wa.size() == 0) check(0, "R10 unexpected write", a0, 0);
            else begin
              logic [31:0] xa, xd;
              xa = exp_wa.pop_front(); xd = exp_wd.pop_front();
              check(a0 == xa, "R10 write addr", a0, xa);
              check(d0 == xd, "R10 write data", d0, xd);
            end
          end else mem_rdata_i = word_at(a0);
          mem_ack_i = 1'b1;
          ack_cyc = cyc;
          age = 0;
        end
      end
    end
  end

  // read-data monitor
  initial begin : rd_monitor
    forever begin
      @(rd_ev);
      begin
        logic [15:0] v;
        string t;
        v = exp_val.pop_front();
        t = exp_tag.pop_front();
        check(bus_rdata_o == v, t, {16'h0, bus_rdata_o}, {16'h0, v});
      end
    end
  end

  task automatic access(input logic [1:0] sel, input logic rd, input logic hf,
                        input logic [15:0] wd, input logic exp_wait, input string tag,
                        input logic chk_data, input logic [15:0] exp_data);
    if (chk_data) begin
      exp_val.push_back(exp_data);
      exp_tag.push_back(tag);
    end
    @(negedge clk_i);
    cs_ni = 1'b0; strb_ni = 1'b0; reg_sel_i = sel; rnw_i = rd; half_i = hf; bus_wdata_i = wd;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    check(wait_o == exp_wait, {tag, " wait level"}, {31'h0, wait_o}, {31'h0, exp_wait});
    if (exp_wait) begin
      for (int n = 0; n < 100 && wait_o; n++) @(negedge clk_i);
      check(cyc == ack_cyc + 1, {tag, " wait release"}, cyc, ack_cyc + 1);
    end
    if (chk_data) -> rd_ev;
    @(negedge clk_i);
    strb_ni = 1'b1; cs_ni = 1'b1;
    repeat (IDLE) @(negedge clk_i);
  endtask

  task automatic write_addr(input logic [31:0] a);
    access(2'b10, 1'b0, 1'b0, a[15:0],  1'b1, "R5", 1'b0, '0);
    access(2'b10, 1'b0, 1'b1, a[31:16], 1'b1, "R5", 1'b0, '0);
    ea = a;
  endtask

  task automatic read_addr(input string tag);
    access(2'b10, 1'b1, 1'b0, '0, 1'b0, tag, 1'b1, ea[15:0]);
    access(2'b10, 1'b1, 1'b1, '0, 1'b0, tag, 1'b1, ea[31:16]);
  endtask

  task automatic read_word(input logic [1:0] sel, input logic first_wait, input string tag);
    logic [31:0] w;
    w = word_at(ea);
    access(sel, 1'b1, 1'b0, '0, first_wait, tag, 1'b1, w[15:0]);
    access(sel, 1'b1, 1'b1, '0, 1'b0,       tag, 1'b1, w[31:16]);
    if (sel == 2'b01) ea = ea + 32'd4;
  endtask

  task automatic write_word(input logic [1:0] sel, input logic [31:0] d);
    exp_wa.push_back(ea); exp_wd.push_back(d);
    access(sel, 1'b0, 1'b0, d[15:0],  1'b0, "R10", 1'b0, '0);
    access(sel, 1'b0, 1'b1, d[31:16], 1'b0, "R10", 1'b0, '0);
    if (sel == 2'b01) ea = ea + 32'd4;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    ea = '0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check(wait_o == 1'b0, "R1 wait", {31'h0, wait_o}, 0);
    check(mem_req_o == 1'b0, "R1 req", {31'h0, mem_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 / R4: control register halves
    access(2'b00, 1'b0, 1'b0, 16'h1234, 1'b0, "R4", 1'b0, '0);
    access(2'b00, 1'b0, 1'b1, 16'hABCD, 1'b0, "R4", 1'b0, '0);
    access(2'b00, 1'b1, 1'b0, '0, 1'b0, "R2", 1'b1, 16'h1234);
    access(2'b00, 1'b1, 1'b1, '0, 1'b0, "R2", 1'b1, 16'hABCD);

    // R5 address halves wait, R4 readback without wait
    write_addr(32'h0000_0100);
    read_addr("R4");

    // R6 fixed read, R10 posted write, read back
    read_word(2'b11, 1'b1, "R6");
    write_word(2'b11, 32'hDEAD_BEEF);
    read_word(2'b11, 1'b1, "R6");

    // R7 auto-increment burst, R8 address advance
    write_addr(32'h0000_0200);
    for (int k = 0; k < 4; k++) read_word(2'b01, (k == 0), "R7");
    read_addr("R8");

    // R9 address write drops prefetch
    write_addr(32'h0000_0300);
    read_word(2'b01, 1'b1, "R9");

    // R10 auto-increment write, R8 advance, R9 data write drops prefetch
    write_word(2'b01, 32'h55AA_1357);
    read_addr("R8");
    read_word(2'b01, 1'b1, "R9");

    // R3: chip select released while waiting on memory
    @(negedge clk_i);
    cs_ni = 1'b0; strb_ni = 1'b0; reg_sel_i = 2'b10; rnw_i = 1'b0; half_i = 1'b0; bus_wdata_i = 16'h0400;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    check(wait_o == 1'b1, "R5 wait level", {31'h0, wait_o}, 1);
    cs_ni = 1'b1;
    #1;
    check(wait_o == 1'b0, "R3 cs released", {31'h0, wait_o}, 0);
    repeat (MEM_LAT + 3) @(negedge clk_i);
    check(wait_o == 1'b0, "R3 idle", {31'h0, wait_o}, 0);
    strb_ni = 1'b1;
    ea = {ea[31:16], 16'h0400};
    repeat (IDLE) @(negedge clk_i);
    read_addr("R4");
    read_word(2'b11, 1'b1, "R6");

    repeat (10) @(negedge clk_i);
    check(exp_wa.size() == 0, "R10 pending writes", exp_wa.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule